// File: doc/BRIEF.md
# Data Tenure Grant Qualifier

This block sits inside a bus master on a split-transaction bus, next to the address-tenure logic. An address start that carries data is an implicit request for the data bus, so the block has no request output of its own. After such a start, the block waits a fixed number of cycles for the snoop response. It then samples the data-bus grant together with three bus-condition lines. When all four agree, it emits a one-cycle `dt_start` pulse that launches the data tenure.

The snoop "shared" reply is captured in the same cycle as the address-retry reply. It decides how the incoming line is allocated: shared-unmodified or exclusive. A retry in that cycle cancels the request and clears the captured reply. An address start that arrives while a request is still pending sets a sticky protocol-error flag.

The state machine has four states:
- `ST_IDLE`: nothing pending.
- `ST_SNOOP`: counting out the snoop window.
- `ST_WAIT`: waiting for a qualified grant.
- `ST_GRANT`: the single `dt_start` cycle.

Named transitions:
- IDLE→SNOOP: data start.
- SNOOP→IDLE: retry cancel.
- SNOOP→WAIT: snoop clean.
- WAIT→GRANT: bus free.
- GRANT→SNOOP: back-to-back start.
- GRANT→IDLE: tenure launched.

Top module: `data_tenure_gate`

## Requirements
- R1: In ST_WAIT, a cycle with `dbus_grant`=1 and `dbus_busy`=0, `dbus_retry`=0 and `abus_retry`=0 all sampled at one edge makes `dt_start` 1 in the cycle after that edge; with any of the three blockers at 1 there is no `dt_start`.
- R2: Either `addr_start` or `addr_start_x` at 1 with `addr_only`=0, sampled in ST_IDLE, makes `req_pending` 1 in the next cycle.
- R3: A start with `addr_only`=1 creates no request: `req_pending` stays 0 and no `dt_start` follows, even with the bus free and granted.
- R4: `dbus_grant` sampled while no request is pending has no effect: no `dt_start` results from it.
- R5: While `dbus_grant` is 0, a request that has cleared the snoop window stays pending (`req_pending`=1) for as many cycles as it takes.
- R6: The snoop reply is sampled at edge SNOOP_LAT after the start edge. `snoop_shared`=1 with `abus_retry`=0 there makes `alloc_shared` 1 during the `dt_start` cycle.
- R7: `snoop_shared`=0 with `abus_retry`=0 at the sample edge makes `alloc_shared` 0 during the `dt_start` cycle (line held by no other cache).
- R8: `abus_retry`=1 at the sample edge cancels the request. In the next cycle `req_pending` is 0 and `alloc_shared` is 0, and a later grant produces no `dt_start`.
- R9: `dt_start` lasts exactly one cycle, after which the block is idle. A data start sampled during the `dt_start` cycle is accepted as a new request.
- R10: Any address start sampled while `req_pending` is 1 sets `proto_err` from the next cycle. The flag holds until reset, and the pending request continues unaffected.
- R11: A synchronous active-high `rst` clears `req_pending`, `alloc_shared`, `proto_err` and `dt_start` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_start | input | 1 | Normal address-start strobe |
| addr_start_x | input | 1 | Extended address-start strobe |
| addr_only | input | 1 | Qualifies the strobe as address-only (no data) |
| dbus_grant | input | 1 | Data-bus grant from the arbiter |
| dbus_busy | input | 1 | Data bus occupied by another tenure |
| dbus_retry | input | 1 | Data-retry in progress |
| abus_retry | input | 1 | Address-retry reply |
| snoop_shared | input | 1 | Snoop reply: line present in another cache |
| dt_start | output | 1 | One-cycle qualified grant, starts the data tenure |
| alloc_shared | output | 1 | Captured shared reply; 1 = allocate shared-unmodified |
| req_pending | output | 1 | A data request is outstanding |
| proto_err | output | 1 | Sticky: address start seen while a request was pending |

## Verification
Some rules are checked by the embedded assertions on every cycle:
- every `dt_start` is preceded by a free, granted bus;
- the pulse never stretches;
- no `dt_start` follows a cycle with nothing pending;
- address-only starts never open a request;
- a retry at the sample edge empties the machine and the shared latch;
- the error flag never falls outside reset.

Other behaviours need the bench's scenarios:
- the exact cycle of each pulse under each blocker;
- which allocation state accompanies it;
- acceptance of a start during the grant cycle;
- the effect of reset in the middle of a request.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SNOOP = 2'd1,
        ST_WAIT  = 2'd2,
        ST_GRANT = 2'd3
    } dtg_state_e;
endpackage

// File: rtl/dtg_free_check.sv
// Bus-free qualifier: grant counts only when every blocker line is low.
module dtg_free_check #(
    parameter int N_BLOCK = 3
) (
    input  logic               grant,
    input  logic [N_BLOCK-1:0] blockers,
    output logic               free
);
    assign free = grant & ~(|blockers);
endmodule

// File: rtl/dtg_snoop_cnt.sv
// Counts out the snoop window; done is high in its last cycle.
module dtg_snoop_cnt #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    localparam int W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [W-1:0] LOAD_VAL = W'(LAT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_VAL;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/dtg_share_latch.sv
// Holds the snoop shared reply for the pending fill.
module dtg_share_latch (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic clear,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            q <= 1'b0;
        else if (capture)
            q <= d;
    end

    // R8: a clear always empties the latch
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (clear && !capture) |=> !q);
endmodule

// File: rtl/dtg_fsm.sv
module dtg_fsm
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_any,
    input  logic addr_only,
    input  logic snoop_done,
    input  logic addr_retry,
    input  logic bus_free,
    output logic load_cnt,
    output logic capture,
    output logic clear_share,
    output logic dt_start,
    output logic req_pending,
    output logic proto_err
);
    dtg_state_e state, state_nx;
    logic data_start;

    assign data_start = start_any & ~addr_only;

    // next-state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (data_start) state_nx = ST_SNOOP;
            ST_SNOOP: if (snoop_done) state_nx = addr_retry ? ST_IDLE : ST_WAIT;
            ST_WAIT:  if (bus_free)   state_nx = ST_GRANT;
            ST_GRANT: state_nx = data_start ? ST_SNOOP : ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register and sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            proto_err <= 1'b0;
        end else begin
            state <= state_nx;
            if (req_pending && start_any)
                proto_err <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_cnt    = 1'b0;
        capture     = 1'b0;
        clear_share = 1'b0;
        dt_start    = 1'b0;
        req_pending = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load_cnt    = data_start;
                clear_share = data_start;
            end
            ST_SNOOP: begin
                req_pending = 1'b1;
                capture     = snoop_done & ~addr_retry;
                clear_share = snoop_done & addr_retry;
            end
            ST_WAIT: begin
                req_pending = 1'b1;
            end
            ST_GRANT: begin
                dt_start    = 1'b1;
                load_cnt    = data_start;
                clear_share = data_start;
            end
            default: ;
        endcase
    end

    // R8: retry at the sample edge returns to idle
    a_r8_retry_cancels: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SNOOP && snoop_done && addr_retry) |=> (state == ST_IDLE));

    // R10: error flag is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);
endmodule

// File: rtl/data_tenure_gate.sv
module data_tenure_gate #(
    parameter int SNOOP_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic addr_start,
    input  logic addr_start_x,
    input  logic addr_only,
    input  logic dbus_grant,
    input  logic dbus_busy,
    input  logic dbus_retry,
    input  logic abus_retry,
    input  logic snoop_shared,
    output logic dt_start,
    output logic alloc_shared,
    output logic req_pending,
    output logic proto_err
);
    localparam int N_BLOCK = 3;

    logic             bus_free, snoop_done, load_cnt, capture, clear_share;
    logic [N_BLOCK-1:0] blockers;

    assign blockers = {dbus_busy, dbus_retry, abus_retry};

    dtg_free_check #(.N_BLOCK(N_BLOCK)) u_free (
        .grant    (dbus_grant),
        .blockers (blockers),
        .free     (bus_free)
    );

    dtg_snoop_cnt #(.LAT(SNOOP_LAT)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (load_cnt),
        .done (snoop_done)
    );

    dtg_share_latch u_share (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .clear   (clear_share),
        .d       (snoop_shared),
        .q       (alloc_shared)
    );

    dtg_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_any   (addr_start | addr_start_x),
        .addr_only   (addr_only),
        .snoop_done  (snoop_done),
        .addr_retry  (abus_retry),
        .bus_free    (bus_free),
        .load_cnt    (load_cnt),
        .capture     (capture),
        .clear_share (clear_share),
        .dt_start    (dt_start),
        .req_pending (req_pending),
        .proto_err   (proto_err)
    );

    // R1: every pulse follows a free, granted bus
    a_r1_grant_needs_free_bus: assert property (@(posedge clk) disable iff (rst)
        dt_start |-> $past(dbus_grant && !dbus_busy && !dbus_retry && !abus_retry));

    // R9: pulse is exactly one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        dt_start |=> !dt_start);

    // R4: nothing pending means no pulse next cycle
    a_r4_no_pulse_unrequested: assert property (@(posedge clk) disable iff (rst)
        !req_pending |=> !dt_start);

    // R3: address-only start opens no request
    a_r3_addr_only_ignored: assert property (@(posedge clk) disable iff (rst)
        (!req_pending && (addr_start || addr_start_x) && addr_only) |=> !req_pending);
endmodule

// File: tb/data_tenure_gate_bench.sv
module data_tenure_gate_bench;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_start = 0, addr_start_x = 0, addr_only = 0;
    logic dbus_grant = 0, dbus_busy = 0, dbus_retry = 0, abus_retry = 0;
    logic snoop_shared = 0;
    logic dt_start, alloc_shared, req_pending, proto_err;

    always #4 clk = ~clk;  // 125 MHz

    data_tenure_gate #(.SNOOP_LAT(LAT)) u_data_tenure_gate (
        .clk(clk), .rst(rst), .addr_start(addr_start), .addr_start_x(addr_start_x),
        .addr_only(addr_only), .dbus_grant(dbus_grant), .dbus_busy(dbus_busy),
        .dbus_retry(dbus_retry), .abus_retry(abus_retry), .snoop_shared(snoop_shared),
        .dt_start(dt_start), .alloc_shared(alloc_shared), .req_pending(req_pending),
        .proto_err(proto_err)
    );

    typedef struct { int at; logic sh; } exp_t;
    exp_t q[$];
    int cyc = 0, checks = 0, bad = 0;
    bit mon_on = 0, finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor: compare each pulse against the scoreboard
    always @(posedge clk) begin
        #2;
        if (mon_on && dt_start) begin
            if (q.size() == 0) begin
                chk(0, "R4 unexpected dt_start", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(cyc == e.at, "R1 dt_start cycle", cyc, e.at);
                chk(alloc_shared == e.sh, e.sh ? "R6 alloc_shared" : "R7 alloc_shared",
                    int'(alloc_shared), int'(e.sh));
            end
        end
    end

    // blk: 0 none, 1 busy, 2 data retry, 3 address retry
    task automatic txn(input bit ext, input bit sh, input bit rty, input int hold,
                       input int blk, input int nb, input bit nowait);
        if (!nowait) @(negedge clk);
        if (ext) addr_start_x = 1; else addr_start = 1;
        addr_only = 0; snoop_shared = sh; abus_retry = rty;
        @(negedge clk);
        addr_start = 0; addr_start_x = 0;
        chk(req_pending == 1, "R2 req_pending", int'(req_pending), 1);
        repeat (LAT) @(negedge clk);
        snoop_shared = 0; abus_retry = 0;
        if (rty) begin
            chk(req_pending == 0, "R8 req_pending", int'(req_pending), 0);
            chk(alloc_shared == 0, "R8 alloc_shared", int'(alloc_shared), 0);
            return;
        end
        for (int i = 0; i < hold; i++) begin
            chk(req_pending == 1, "R5 held", int'(req_pending), 1);
            @(negedge clk);
        end
        dbus_grant = 1;
        dbus_busy = (blk == 1); dbus_retry = (blk == 2); abus_retry = (blk == 3);
        repeat (nb) @(negedge clk);
        if (nb > 0) chk(req_pending == 1, "R1 blocked", int'(req_pending), 1);
        dbus_busy = 0; dbus_retry = 0; abus_retry = 0;
        q.push_back('{at: cyc + 1, sh: sh});
        @(negedge clk);
        dbus_grant = 0;
    endtask

    initial begin
        #(8 * 50000);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dt_start == 0 && req_pending == 0 && proto_err == 0 && alloc_shared == 0,
            "R11 reset state", int'(req_pending), 0);
        rst = 0; mon_on = 1;

        // R4: early grant while idle
        @(negedge clk); dbus_grant = 1;
        repeat (5) @(negedge clk);
        chk(req_pending == 0, "R4 idle grant", int'(req_pending), 0);

        // R3: address-only start with free bus
        addr_start = 1; addr_only = 1;
        @(negedge clk); addr_start = 0; addr_only = 0;
        chk(req_pending == 0, "R3 no request", int'(req_pending), 0);
        repeat (4) @(negedge clk);
        dbus_grant = 0;
        chk(req_pending == 0, "R3 still idle", int'(req_pending), 0);

        txn(0, 1, 0, 0, 0, 0, 0);  // R6 shared
        txn(1, 0, 0, 3, 0, 0, 0);  // R2 extended strobe, R5 hold, R7 exclusive
        txn(0, 0, 0, 0, 1, 3, 0);  // R1 busy
        txn(0, 1, 0, 1, 2, 2, 0);  // R1 data retry
        txn(1, 0, 0, 0, 3, 2, 0);  // R1 address retry after window

        // R8 cancel, then grant must not pulse
        txn(0, 1, 1, 0, 0, 0, 0);
        dbus_grant = 1;
        repeat (3) @(negedge clk);
        dbus_grant = 0;
        chk(req_pending == 0, "R8 stays idle", int'(req_pending), 0);

        // R9 back-to-back: new start sampled during the pulse cycle
        txn(0, 0, 0, 0, 0, 0, 0);
        chk(dt_start == 1, "R9 pulse cycle", int'(dt_start), 1);
        txn(0, 1, 0, 0, 0, 0, 1);
        chk(dt_start == 1, "R9 second pulse", int'(dt_start), 1);
        @(negedge clk);
        chk(dt_start == 0, "R9 one cycle", int'(dt_start), 0);
        chk(proto_err == 0, "R10 no false error", int'(proto_err), 0);

        // R10 start while pending
        addr_start = 1;
        @(negedge clk); addr_start = 0;
        @(negedge clk); addr_start_x = 1;
        @(negedge clk); addr_start_x = 0;
        chk(proto_err == 1, "R10 error set", int'(proto_err), 1);
        chk(req_pending == 1, "R10 request kept", int'(req_pending), 1);
        repeat (2) @(negedge clk);
        dbus_grant = 1;
        q.push_back('{at: cyc + 1, sh: 1'b0});
        @(negedge clk); dbus_grant = 0;
        repeat (2) @(negedge clk);
        chk(proto_err == 1, "R10 sticky", int'(proto_err), 1);

        // R11 reset mid-request
        snoop_shared = 1;
        addr_start = 1;
        @(negedge clk); addr_start = 0;
        repeat (LAT) @(negedge clk);
        snoop_shared = 0;
        rst = 1;
        @(negedge clk); rst = 0;
        chk(req_pending == 0, "R11 pending cleared", int'(req_pending), 0);
        chk(alloc_shared == 0, "R11 shared cleared", int'(alloc_shared), 0);
        chk(proto_err == 0, "R11 error cleared", int'(proto_err), 0);
        dbus_grant = 1;
        repeat (3) @(negedge clk);
        dbus_grant = 0;

        repeat (2) @(negedge clk);
        chk(q.size() == 0, "R1 missing pulses", q.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule